// File: doc/BRIEF.md
# Wide-to-Narrow Peripheral Access Converter

This block sits between a 32-bit host register port and one module slot whose bus is natively 16 bits wide but may also carry full 32-bit transfers. Each host request is a single-cycle pulse carrying a long-word address, four byte enables and write data. The block turns it into one or two peripheral bus cycles. It holds each cycle until the peripheral acknowledges, and it returns a single acknowledge, with assembled read data, to the host.

The address window picks the transfer width. The top bit of the host long-word address selects the 32-bit window, where every request is one full-width cycle. Otherwise the request goes to the 16-bit window. There, a request whose byte enables touch both 16-bit halves is split into two ordered narrow cycles, lower half first. A request that touches only one half becomes a single narrow cycle. Three slot controls are sampled when a request is accepted: swap bytes within each halfword, swap the two halfwords, and keep the second cycle's address static instead of advancing it by two.

Top module: `wide_narrow_bridge`

## Requirements
- R1: After reset `host_ack` and `per_cyc` are low.
- R2: In the 16-bit window (`host_lw_addr` top bit 0), a request with all four byte enables set and no swaps gives two narrow cycles. The first carries host bits 15..0 at byte address `{index,2'b00}`. The second carries bits 31..16 at that address plus 2.
- R3: With `cfg_addr_static` set, the second cycle of a split uses the same address as the first, so one halfword location is accessed twice.
- R4: On a split read, the first halfword returned is placed in host bits 15..0 and the second in bits 31..16. The word is presented only with the acknowledge that follows the second cycle.
- R5: In the 32-bit window (`host_lw_addr` top bit 1), any request is one cycle with `per_wide` high, address `{index,2'b00}`, and the host byte enables and data on all four lanes.
- R6: In the 16-bit window, a request whose (swapped) enables lie in a single half is one narrow cycle. The upper half uses address plus 2. The data travels on peripheral lanes 15..0, and read data returns in the host lanes of that half.
- R7: `cfg_byte_swap` exchanges the two bytes inside each halfword. Host byte k then reaches byte address base+(k XOR 1), in both directions.
- R8: `cfg_word_swap` exchanges the halfwords, so host byte k maps to base+(k XOR 2). With both swaps set, k maps to base+(k XOR 3).
- R9: `host_ack` is high for exactly one cycle per accepted request, in the cycle after the final `per_ack`. Requests pulsed while an access is in progress are ignored.
- R10: A peripheral cycle keeps `per_cyc`, address, data, enables and direction stable until `per_ack`. Both cycles of a split stay inside the same long word.
- R11: In the 16-bit window, a partial request whose enables span both halves (e.g. 4'b0110) is split into two cycles. Each cycle carries only its own half's enables on lanes 1..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_byte_swap | input | 1 | Swap bytes within each halfword |
| cfg_word_swap | input | 1 | Swap the two halfwords |
| cfg_addr_static | input | 1 | Second split cycle reuses the first address |
| host_req | input | 1 | One-cycle request pulse |
| host_we | input | 1 | 1 = write, 0 = read |
| host_lw_addr | input | ADDR_W-2 | Long-word address; top bit selects the 32-bit window |
| host_be | input | 4 | Host byte enables, bit k = byte lane k |
| host_wdata | input | 32 | Host write data |
| host_ack | output | 1 | One-cycle completion strobe |
| host_rdata | output | 32 | Read data, valid with host_ack |
| per_cyc | output | 1 | Peripheral cycle in progress |
| per_we | output | 1 | Peripheral write |
| per_wide | output | 1 | Current cycle is 32-bit |
| per_addr | output | ADDR_W-1 | Peripheral byte address inside the slot |
| per_be | output | 4 | Peripheral byte enables |
| per_wdata | output | 32 | Peripheral write data |
| per_ack | input | 1 | Peripheral completion, one cycle |
| per_rdata | input | 32 | Peripheral read data, valid with per_ack |

## Verification
Long-word writes and reads go to the 16-bit window with the address mode set to increment and then to static. This separates lower-first ordering from a swapped order and separates an advancing second address from a repeated one. Single-byte and single-half requests in each half, and a mid-word partial request, show whether the block picks one cycle or two from the enables and whether it routes the upper half onto the low lanes. Each swap setting writes a known pattern and reads it back, so every byte's landing place is visible in memory. A second request pulsed during a slow peripheral cycle, plus a 32-bit-window request, confirm that only one acknowledge is produced and that the window alone sets the width.

// File: rtl/wnb_pkg.sv
// Shared types for the wide-to-narrow converter.
// Assumes a 32-bit host word made of two 16-bit halves.
package wnb_pkg;
    localparam int HOST_W = 32;
    localparam int HALF_W = HOST_W / 2;
    localparam int LANES  = HOST_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CYC1 = 2'd1,
        ST_CYC2 = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;
endpackage

// File: rtl/wnb_lane_swap.sv
// Lane permutation for a four-lane word.
// Word swap exchanges the two halves; byte swap exchanges the lanes inside each half.
// Both are self-inverse, so one instance serves the write and read directions.
// LANE_W = 8 for data and 1 for byte enables.
module wnb_lane_swap #(
    parameter int LANE_W = 8
) (
    input  logic                byte_swap,
    input  logic                word_swap,
    input  logic [4*LANE_W-1:0] din,
    output logic [4*LANE_W-1:0] dout
);
    localparam int PAIR_W = 2 * LANE_W;

    logic [4*LANE_W-1:0] halves;

    // Halfword exchange stage.
    assign halves = word_swap ? {din[PAIR_W-1:0], din[4*LANE_W-1:PAIR_W]} : din;

    // Byte exchange stage, one copy per half.
    generate
        for (genvar h = 0; h < 2; h++) begin : g_half
            assign dout[h*PAIR_W +: LANE_W] = byte_swap ?
                halves[h*PAIR_W+LANE_W +: LANE_W] : halves[h*PAIR_W +: LANE_W];
            assign dout[h*PAIR_W+LANE_W +: LANE_W] = byte_swap ?
                halves[h*PAIR_W +: LANE_W] : halves[h*PAIR_W+LANE_W +: LANE_W];
        end
    endgenerate
endmodule

// File: rtl/wnb_seq.sv
// Access sequencer: idle, first cycle, optional second cycle, host completion.
// Assumes per_ack is a one-cycle pulse that ends the current peripheral cycle.
module wnb_seq
    import wnb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       split,
    input  logic       per_ack,
    output seq_state_t state
);
    seq_state_t nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start)   nxt = ST_CYC1;
            ST_CYC1: if (per_ack) nxt = split ? ST_CYC2 : ST_DONE;
            ST_CYC2: if (per_ack) nxt = ST_DONE;
            ST_DONE:              nxt = ST_IDLE;
            default:              nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/wnb_rd_assy.sv
// Read data assembly: collects a full word, or a low and then a high halfword.
// Assumes the capture strobes are mutually exclusive.
module wnb_rd_assy #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cap_full,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [WORD_W-1:0] per_rdata,
    output logic [WORD_W-1:0] word
);
    localparam int HW = WORD_W / 2;

    // Capture register for the assembled word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word <= '0;
        end else if (cap_full) begin
            word <= per_rdata;
        end else if (cap_lo) begin
            word[HW-1:0] <= per_rdata[HW-1:0];
        end else if (cap_hi) begin
            word[WORD_W-1:HW] <= per_rdata[HW-1:0];
        end
    end
endmodule

// File: rtl/wide_narrow_bridge.sv
// Converts single host requests into one or two peripheral cycles for one slot.
// The top long-word address bit selects the 32-bit window. In the 16-bit window,
// enables touching both halves cause a split, with the low half first.
// Assumes host_req is a one-cycle pulse; pulses arriving while busy are dropped.
module wide_narrow_bridge
    import wnb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_byte_swap,
    input  logic              cfg_word_swap,
    input  logic              cfg_addr_static,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-3:0] host_lw_addr,
    input  logic [3:0]        host_be,
    input  logic [31:0]       host_wdata,
    output logic              host_ack,
    output logic [31:0]       host_rdata,
    output logic              per_cyc,
    output logic              per_we,
    output logic              per_wide,
    output logic [ADDR_W-2:0] per_addr,
    output logic [3:0]        per_be,
    output logic [31:0]       per_wdata,
    input  logic              per_ack,
    input  logic [31:0]       per_rdata
);
    localparam int WIN_BIT = ADDR_W - 3;
    localparam int IDX_W   = ADDR_W - 3;

    seq_state_t state;

    logic [HOST_W-1:0] sw_wdata;
    logic [LANES-1:0]  sw_be;
    logic              start;
    logic              wide_win;
    logic              split_req;
    logic              hi_req;

    logic              r_we, r_wide, r_split, r_hi, r_static, r_bsw, r_wsw;
    logic [IDX_W-1:0]  r_idx;
    logic [HOST_W-1:0] r_data;
    logic [LANES-1:0]  r_be;

    logic              in_cyc2;
    logic              data_hi;
    logic              addr_hi;
    logic [HOST_W-1:0] asm_word;
    logic [HOST_W-1:0] unswapped;

    // Host-side lane permutation of data and enables.
    wnb_lane_swap #(.LANE_W(8)) u_wr_swap (
        .byte_swap (cfg_byte_swap),
        .word_swap (cfg_word_swap),
        .din       (host_wdata),
        .dout      (sw_wdata)
    );

    wnb_lane_swap #(.LANE_W(1)) u_be_swap (
        .byte_swap (cfg_byte_swap),
        .word_swap (cfg_word_swap),
        .din       (host_be),
        .dout      (sw_be)
    );

    // Request classification: window, split, and which half a single cycle uses.
    always_comb begin
        start     = (state == ST_IDLE) && host_req;
        wide_win  = host_lw_addr[WIN_BIT];
        split_req = !wide_win && (|sw_be[1:0]) && (|sw_be[3:2]);
        hi_req    = !(|sw_be[1:0]) && (|sw_be[3:2]);
    end

    // Request latch, loaded only when the sequencer is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_we     <= 1'b0;
            r_wide   <= 1'b0;
            r_split  <= 1'b0;
            r_hi     <= 1'b0;
            r_static <= 1'b0;
            r_bsw    <= 1'b0;
            r_wsw    <= 1'b0;
            r_idx    <= '0;
            r_data   <= '0;
            r_be     <= '0;
        end else if (start) begin
            r_we     <= host_we;
            r_wide   <= wide_win;
            r_split  <= split_req;
            r_hi     <= hi_req;
            r_static <= cfg_addr_static;
            r_bsw    <= cfg_byte_swap;
            r_wsw    <= cfg_word_swap;
            r_idx    <= host_lw_addr[IDX_W-1:0];
            r_data   <= sw_wdata;
            r_be     <= sw_be;
        end
    end

    wnb_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .split   (r_split),
        .per_ack (per_ack),
        .state   (state)
    );

    // Half selection for data and for the address of the current cycle.
    always_comb begin
        in_cyc2 = (state == ST_CYC2);
        data_hi = in_cyc2 || (!r_split && r_hi);
        addr_hi = data_hi && !(in_cyc2 && r_static);
    end

    // Peripheral-side drive.
    always_comb begin
        per_cyc  = (state == ST_CYC1) || (state == ST_CYC2);
        per_we   = r_we;
        per_wide = per_cyc && r_wide;
        if (r_wide) begin
            per_addr  = {r_idx, 2'b00};
            per_wdata = r_data;
            per_be    = r_be;
        end else begin
            per_addr  = {r_idx, addr_hi, 1'b0};
            per_wdata = {{HALF_W{1'b0}}, data_hi ? r_data[HOST_W-1:HALF_W] : r_data[HALF_W-1:0]};
            per_be    = {2'b00, data_hi ? r_be[3:2] : r_be[1:0]};
        end
    end

    wnb_rd_assy #(.WORD_W(HOST_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .cap_full  (per_ack && (state == ST_CYC1) && r_wide),
        .cap_lo    (per_ack && (state == ST_CYC1) && !r_wide && (r_split || !r_hi)),
        .cap_hi    (per_ack && !r_wide && (in_cyc2 || ((state == ST_CYC1) && !r_split && r_hi))),
        .per_rdata (per_rdata),
        .word      (asm_word)
    );

    // Undo the slot's lane permutation on the returned word.
    wnb_lane_swap #(.LANE_W(8)) u_rd_swap (
        .byte_swap (r_bsw),
        .word_swap (r_wsw),
        .din       (asm_word),
        .dout      (unswapped)
    );

    // Host completion.
    always_comb begin
        host_ack   = (state == ST_DONE);
        host_rdata = host_ack ? unswapped : '0;
    end
endmodule

// File: rtl/wnb_checker.sv
// Protocol checker for wide_narrow_bridge, attached by bind.
module wnb_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ack,
    input logic              per_cyc,
    input logic              per_ack,
    input logic              per_wide,
    input logic              per_we,
    input logic [ADDR_W-2:0] per_addr,
    input logic [3:0]        per_be,
    input logic [31:0]       per_wdata
);
    // R1: reset leaves both strobes low.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!host_ack && !per_cyc));

    // R9: acknowledge is a single-cycle pulse.
    a_r9_ack_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R9: acknowledge comes right after a peripheral acknowledge, with no cycle open.
    a_r9_ack_follows_per_ack: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> ($past(per_ack) && !per_cyc));

    // R10: an open cycle holds all its fields until acknowledged.
    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (per_cyc && !per_ack) |=> (per_cyc && $stable(per_addr) && $stable(per_wdata)
                                   && $stable(per_be) && $stable(per_we)));

    // R10: a following narrow cycle stays in the same long word.
    a_r10_same_longword: assert property (@(posedge clk) disable iff (!rst_n)
        (per_cyc && per_ack && !per_wide) |=>
            (!per_cyc || (per_addr[ADDR_W-2:2] == $past(per_addr[ADDR_W-2:2]))));

    // R5: wide cycles are long-word aligned.
    a_r5_wide_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (per_cyc && per_wide) |-> (per_addr[1:0] == 2'b00));

    // R6: narrow cycles use only the low two lanes at a halfword address.
    a_r6_narrow_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (per_cyc && !per_wide) |-> ((per_be[3:2] == 2'b00) && !per_addr[0]
                                    && (per_wdata[31:16] == 16'h0)));
endmodule

bind wide_narrow_bridge wnb_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/wide_narrow_bridge_tb.sv
// Directed bench: one task per scenario, with a byte-addressed peripheral model.
module wide_narrow_bridge_tb;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_byte_swap = 1'b0, cfg_word_swap = 1'b0, cfg_addr_static = 1'b0;
    logic              host_req = 1'b0, host_we = 1'b0;
    logic [ADDR_W-3:0] host_lw_addr = '0;
    logic [3:0]        host_be = '0;
    logic [31:0]       host_wdata = '0;
    logic              host_ack;
    logic [31:0]       host_rdata;
    logic              per_cyc, per_we, per_wide;
    logic [ADDR_W-2:0] per_addr;
    logic [3:0]        per_be;
    logic [31:0]       per_wdata;
    logic              per_ack = 1'b0;
    logic [31:0]       per_rdata = '0;

    int n_checks = 0, n_fail = 0;
    int lat = 0, wait_cnt = 0, n_tot = 0, ack_cnt = 0;
    logic [7:0]        mem [0:255];
    logic [ADDR_W-2:0] log_addr [0:63];
    logic              log_wide [0:63];
    logic [3:0]        log_be   [0:63];

    wide_narrow_bridge #(.ADDR_W(ADDR_W)) u_dut (.*);

    always #10 clk = ~clk;

    // Peripheral model: acknowledges after lat wait cycles, logs each cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            per_ack  <= 1'b0;
            wait_cnt <= 0;
        end else if (per_cyc && !per_ack) begin
            if (wait_cnt >= lat) begin
                per_ack  <= 1'b1;
                wait_cnt <= 0;
                log_addr[n_tot % 64] <= per_addr;
                log_wide[n_tot % 64] <= per_wide;
                log_be[n_tot % 64]   <= per_be;
                n_tot <= n_tot + 1;
                if (per_we) begin
                    for (int k = 0; k < 4; k++)
                        if (per_be[k]) mem[(int'(per_addr[7:0]) + k) % 256] <= per_wdata[8*k +: 8];
                end else if (per_wide) begin
                    per_rdata <= {mem[(int'(per_addr[7:0]) + 3) % 256], mem[(int'(per_addr[7:0]) + 2) % 256],
                                  mem[(int'(per_addr[7:0]) + 1) % 256], mem[int'(per_addr[7:0])]};
                end else begin
                    per_rdata <= {16'h0, mem[(int'(per_addr[7:0]) + 1) % 256], mem[int'(per_addr[7:0])]};
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            per_ack <= 1'b0;
        end
    end

    always @(negedge clk) if (host_ack) ack_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    // One host request; returns read data, cycles used and acks seen.
    task automatic access(input logic we, input int baddr, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output int ncyc, output int nack, output int first);
        int a0;
        a0 = ack_cnt;
        first = n_tot;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_lw_addr = 10'(baddr >> 2);
        host_be = be; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        for (int t = 0; t < 200 && !host_ack; t++) @(negedge clk);
        rd = host_rdata;
        ncyc = n_tot - first;
        if (!host_ack) begin
            n_fail++;
            $display("FAIL R9: no host_ack, actual 0 expected 1");
        end
        @(negedge clk);
        @(negedge clk);
        nack = ack_cnt - a0;
    endtask

    function automatic logic [31:0] mem_word(input int b);
        return {mem[b + 3], mem[b + 2], mem[b + 1], mem[b]};
    endfunction

    task automatic t_reset();
        chk("R1 host_ack after reset", 32'(host_ack), 32'h0);
        chk("R1 per_cyc after reset", 32'(per_cyc), 32'h0);
    endtask

    task automatic t_split_incr();
        logic [31:0] rd; int nc, na, f;
        clear_mem();
        access(1'b1, 'h10, 4'hF, 32'h44332211, rd, nc, na, f);
        chk("R2 cycle count", 32'(nc), 32'd2);
        chk("R2 first addr", 32'(log_addr[f % 64]), 32'h10);
        chk("R2 second addr", 32'(log_addr[(f + 1) % 64]), 32'h12);
        chk("R2 memory bytes", mem_word('h10), 32'h44332211);
        chk("R9 one ack", 32'(na), 32'd1);
        mem['h20] = 8'hA1; mem['h21] = 8'hB2; mem['h22] = 8'hC3; mem['h23] = 8'hD4;
        lat = 3;
        access(1'b0, 'h20, 4'hF, 32'h0, rd, nc, na, f);
        chk("R4 split read data", rd, 32'hD4C3B2A1);
        chk("R4 two cycles before ack", 32'(nc), 32'd2);
        chk("R9 one ack slow peripheral", 32'(na), 32'd1);
        lat = 0;
    endtask

    task automatic t_static();
        logic [31:0] rd; int nc, na, f;
        clear_mem();
        cfg_addr_static = 1'b1;
        access(1'b1, 'h30, 4'hF, 32'hBBBBAAAA, rd, nc, na, f);
        chk("R3 both addrs equal", 32'(log_addr[(f + 1) % 64]), 32'(log_addr[f % 64]));
        chk("R3 location holds upper half", {mem['h31], mem['h30]}, 32'h0000BBBB);
        chk("R3 next halfword untouched", {mem['h33], mem['h32]}, 32'h0);
        mem['h30] = 8'h5A; mem['h31] = 8'hC3;
        access(1'b0, 'h30, 4'hF, 32'h0, rd, nc, na, f);
        chk("R3 static read twice", rd, 32'hC35AC35A);
        cfg_addr_static = 1'b0;
    endtask

    task automatic t_wide();
        logic [31:0] rd; int nc, na, f;
        clear_mem();
        access(1'b1, 'h840, 4'hF, 32'hCAFEF00D, rd, nc, na, f);
        chk("R5 single cycle", 32'(nc), 32'd1);
        chk("R5 wide flag", 32'(log_wide[f % 64]), 32'h1);
        chk("R5 address", 32'(log_addr[f % 64]), 32'h40);
        chk("R5 memory", mem_word('h40), 32'hCAFEF00D);
        access(1'b0, 'h840, 4'hF, 32'h0, rd, nc, na, f);
        chk("R5 wide read", rd, 32'hCAFEF00D);
        access(1'b1, 'h844, 4'b0010, 32'h00005500, rd, nc, na, f);
        chk("R5 byte to wide site", mem_word('h44), 32'h00005500);
        chk("R5 byte enables kept", 32'(log_be[f % 64]), 32'h2);
    endtask

    task automatic t_single_half();
        logic [31:0] rd; int nc, na, f;
        clear_mem();
        access(1'b1, 'h50, 4'b0100, 32'h00770000, rd, nc, na, f);
        chk("R6 one cycle", 32'(nc), 32'd1);
        chk("R6 upper half addr", 32'(log_addr[f % 64]), 32'h52);
        chk("R6 memory", mem_word('h50), 32'h00770000);
        mem['h53] = 8'h66;
        access(1'b0, 'h50, 4'b1100, 32'h0, rd, nc, na, f);
        chk("R6 upper half read", rd, 32'h66770000);
    endtask

    // Expected byte at base+j is host byte (j XOR code), code = {word,byte}.
    task automatic t_swap(input logic bs, input logic ws);
        logic [31:0] rd, exp; int nc, na, f, code;
        clear_mem();
        cfg_byte_swap = bs; cfg_word_swap = ws;
        code = {30'd0, ws, bs};
        access(1'b1, 'h60, 4'hF, 32'h44332211, rd, nc, na, f);
        for (int j = 0; j < 4; j++) exp[8*j +: 8] = 8'(8'h11 * ((j ^ code) + 1));
        chk(bs && ws ? "R8 both swaps memory" : (ws ? "R8 word swap memory" : "R7 byte swap memory"),
            mem_word('h60), exp);
        access(1'b0, 'h60, 4'hF, 32'h0, rd, nc, na, f);
        chk(ws ? "R8 swap read back" : "R7 swap read back", rd, 32'h44332211);
        cfg_byte_swap = 1'b0; cfg_word_swap = 1'b0;
    endtask

    task automatic t_busy();
        int a0, n0;
        clear_mem();
        lat = 6;
        a0 = ack_cnt; n0 = n_tot;
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_lw_addr = 10'('h80 >> 2);
        host_be = 4'hF; host_wdata = 32'h12345678;
        @(negedge clk); host_req = 1'b0;
        @(negedge clk); @(negedge clk);
        host_req = 1'b1; host_lw_addr = 10'('h90 >> 2); host_wdata = 32'hDEADBEEF;
        @(negedge clk); host_req = 1'b0;
        repeat (40) @(negedge clk);
        chk("R9 busy: single ack", 32'(ack_cnt - a0), 32'd1);
        chk("R9 busy: second request ignored", mem_word('h90), 32'h0);
        chk("R9 busy: only two cycles", 32'(n_tot - n0), 32'd2);
        chk("R9 busy: first request done", mem_word('h80), 32'h12345678);
        lat = 0;
    endtask

    task automatic t_partial();
        logic [31:0] rd; int nc, na, f;
        clear_mem();
        mem['h70] = 8'h01; mem['h73] = 8'h04;
        access(1'b1, 'h70, 4'b0110, 32'h00BBAA00, rd, nc, na, f);
        chk("R11 split count", 32'(nc), 32'd2);
        chk("R11 first enables", 32'(log_be[f % 64]), 32'h2);
        chk("R11 second enables", 32'(log_be[(f + 1) % 64]), 32'h1);
        chk("R11 memory", mem_word('h70), 32'h04BBAA01);
        chk("R10 second addr in long word", 32'(log_addr[(f + 1) % 64]), 32'h72);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_split_incr();
        t_static();
        t_wide();
        t_single_half();
        t_swap(1'b1, 1'b0);
        t_swap(1'b0, 1'b1);
        t_swap(1'b1, 1'b1);
        t_busy();
        t_partial();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule